// File: doc/BRIEF.md
# Boot Mode Capture and External Interrupt Front End

This block sits behind two shared input pins. While the chip is held in reset the pins carry the boot operating mode. After reset the same pins become two external interrupt request lines, called line A and line B. Both pins pass through a synchronizer. The block stores the synchronized pin levels as the operating mode on the first clock edge after reset is released. From then on, software may overwrite that mode through a write strobe.

Each interrupt line has a trigger-select bit that software can write. With the bit clear, the line is level-sensitive: the request output follows the synchronized low level and stores nothing. With the bit set, the line detects a high-to-low transition and raises a sticky request. That request stays up until a per-line acknowledge pulse clears it.

Requests are forced low during reset. They also stay low for one cycle after the mode has been captured, so that the boot strapping levels cannot appear as interrupts. Priority and vectoring are handled downstream.

Top module: `boot_mode_irq_front`

## Requirements
- R1: While `rst_n` is low, `op_mode` and `irq_req` are all zero, and a mode write presented during reset has no effect.
- R2: On the first rising clock edge with `rst_n` high, `op_mode` takes the synchronized pin levels: bit 0 from `line_pin[0]` (line A) and bit 1 from `line_pin[1]` (line B). The pins must have been steady for at least two cycles before the release.
- R3: After capture, `mode_we` high at a clock edge loads `mode_wdata` into `op_mode` at that edge.
- R4: After capture, pin activity never changes `op_mode`. Only a write changes it.
- R5: Trigger-select bit i (written through `trig_we`/`trig_wdata`, effective at that edge) configures line i: 0 selects level mode and 1 selects falling-edge mode. Reset clears both bits to level mode.
- R6: In level mode, `irq_req[i]` is high exactly while the pin, seen two clock edges after a change, is low. It drops again when the pin returns high, with no latching.
- R7: In edge mode, a high-to-low pin transition sets `irq_req[i]` on the third rising edge after the change. The request then stays set when the pin rises again.
- R8: In edge mode, `irq_ack[i]` high at a clock edge clears the request at that edge. If a new falling transition is detected at the same edge, the request stays set.
- R9: Requests stay low during the cycle that follows mode capture, even when a pin is already low.
- R10: The two lines are independent: one line's pin, acknowledge and trigger bit never affect the other line's request.
- R11: In edge mode, a low-to-high transition does not set a request. This includes the case where the line is switched to edge mode while its pin is already low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| line_pin | input | LINES | Shared mode/interrupt pins; bit 0 is line A, bit 1 is line B |
| mode_we | input | 1 | Operating-mode write strobe |
| mode_wdata | input | LINES | Operating-mode write value |
| trig_we | input | 1 | Trigger-select write strobe |
| trig_wdata | input | LINES | Trigger-select value, 1 = falling edge per line |
| irq_ack | input | LINES | Per-line acknowledge pulse for edge-mode requests |
| op_mode | output | LINES | Current operating mode |
| irq_req | output | LINES | Per-line interrupt request |

## Verification
The bench captures a mode whose two bits differ (01, then 10 on a second reset), so a swapped or stuck bit shows up. It then moves the pins after release to show that the stored mode ignores them. Level lines are driven low and back high, which separates following from latching. Edge lines get a fall, a rise, a fall with both lines at once, an acknowledge coinciding with a new fall, and a switch to edge mode while the pin is already low. Together these distinguish edge from level detection, rising from falling, acknowledge priority and cross-line leakage. A pin held low across reset release shows whether the one-cycle mask is present.

// File: rtl/irqm_pkg.sv
package irqm_pkg;
  typedef enum logic {
    TRIG_LEVEL = 1'b0,
    TRIG_FALL  = 1'b1
  } trig_e;

  localparam int unsigned DEF_LINES = 2;
  localparam int unsigned DEF_SYNC  = 2;
endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) chain[0] <= d;

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) chain[s] <= chain[s-1];
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mode_capture.sv
module mode_capture #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins_s,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic         live,
  output logic         arm,
  output logic [W-1:0] op_mode
);
  logic         live_q, live_d;
  logic         arm_q, arm_d;
  logic [W-1:0] mode_q, mode_d;

  always_comb begin
    live_d = 1'b1;
    arm_d  = live_q;
    mode_d = mode_q;
    if (!live_q)    mode_d = pins_s;
    else if (wr_en) mode_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= 1'b0;
      arm_q  <= 1'b0;
      mode_q <= '0;
    end else begin
      live_q <= live_d;
      arm_q  <= arm_d;
      mode_q <= mode_d;
    end
  end

  assign live    = live_q;
  assign arm     = arm_q;
  assign op_mode = mode_q;

  // R2: captured value equals the synchronized pins at the capture edge
  p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(live_q) |-> mode_q == $past(pins_s));
  // R3: a write after capture lands on the next edge
  p_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && wr_en) |=> mode_q == $past(wr_data));
  // R4: without a write the mode holds
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && !wr_en) |=> $stable(mode_q));
endmodule

// File: rtl/irq_line.sv
module irq_line
  import irqm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic pin_s,
  input  logic cfg_we,
  input  logic cfg_bit,
  input  logic ack,
  output logic req
);
  logic  prev_q, prev_d;
  logic  pend_q, pend_d;
  trig_e trig_q, trig_d;
  logic  fall;

  always_comb begin
    prev_d = pin_s;
    fall   = prev_q & ~pin_s;
    trig_d = cfg_we ? trig_e'(cfg_bit) : trig_q;
    pend_d = pend_q;
    if (!arm || trig_q == TRIG_LEVEL) pend_d = 1'b0;
    else if (fall)                    pend_d = 1'b1;
    else if (ack)                     pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      pend_q <= 1'b0;
      trig_q <= TRIG_LEVEL;
    end else begin
      prev_q <= prev_d;
      pend_q <= pend_d;
      trig_q <= trig_d;
    end
  end

  assign req = arm & ((trig_q == TRIG_FALL) ? pend_q : ~pin_s);

  // R7: a detected fall in edge mode raises the request
  p_fall_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && trig_q == TRIG_FALL && fall && !cfg_we) |=> pend_q);
  // R7: the request is sticky until acknowledged
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && trig_q == TRIG_FALL && pend_q && !ack && !cfg_we) |=> pend_q);
  // R8: acknowledge clears when no new fall competes
  p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && trig_q == TRIG_FALL && ack && !fall && !cfg_we) |=> !pend_q);
  // R11: nothing but a fall raises an idle edge request
  p_no_rise_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_q == TRIG_FALL && !pend_q && !fall && !cfg_we) |=> !pend_q);
endmodule

// File: rtl/boot_mode_irq_front.sv
module boot_mode_irq_front
  import irqm_pkg::*;
#(
  parameter int unsigned LINES       = DEF_LINES,
  parameter int unsigned SYNC_STAGES = DEF_SYNC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] line_pin,
  input  logic             mode_we,
  input  logic [LINES-1:0] mode_wdata,
  input  logic             trig_we,
  input  logic [LINES-1:0] trig_wdata,
  input  logic [LINES-1:0] irq_ack,
  output logic [LINES-1:0] op_mode,
  output logic [LINES-1:0] irq_req
);
  logic [LINES-1:0] pin_s;
  logic             live;
  logic             arm;

  bit_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .d   (line_pin),
    .q   (pin_s)
  );

  mode_capture #(.W(LINES)) u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .pins_s  (pin_s),
    .wr_en   (mode_we),
    .wr_data (mode_wdata),
    .live    (live),
    .arm     (arm),
    .op_mode (op_mode)
  );

  for (genvar i = 0; i < LINES; i++) begin : g_line
    irq_line u_line (
      .clk     (clk),
      .rst_n   (rst_n),
      .arm     (arm),
      .pin_s   (pin_s[i]),
      .cfg_we  (trig_we),
      .cfg_bit (trig_wdata[i]),
      .ack     (irq_ack[i]),
      .req     (irq_req[i])
    );
  end

  // R9: no request in the cycle following mode capture
  p_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(live) |-> irq_req == '0);
endmodule

// File: tb/test_boot_mode_irq_front.sv
`timescale 1ns/1ps
module test_boot_mode_irq_front;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] line_pin;
  logic       mode_we;
  logic [1:0] mode_wdata;
  logic       trig_we;
  logic [1:0] trig_wdata;
  logic [1:0] irq_ack;
  logic [1:0] op_mode;
  logic [1:0] irq_req;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    int         at;
    logic [1:0] mode;
    logic [1:0] req;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  boot_mode_irq_front i_boot_mode_irq_front (
    .clk(clk), .rst_n(rst_n), .line_pin(line_pin),
    .mode_we(mode_we), .mode_wdata(mode_wdata),
    .trig_we(trig_we), .trig_wdata(trig_wdata),
    .irq_ack(irq_ack), .op_mode(op_mode), .irq_req(irq_req)
  );

  // monitor: compares at the falling edge
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (e.at != cyc || op_mode !== e.mode || irq_req !== e.req) begin
        failures++;
        $display("FAIL %s cyc=%0d mode=%b req=%b expected mode=%b req=%b",
                 e.tag, cyc, op_mode, irq_req, e.mode, e.req);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic expect_in(input int d, input logic [1:0] m,
                           input logic [1:0] r, input string tag);
    exp_t e;
    e.at = cyc + d; e.mode = m; e.req = r; e.tag = tag;
    sb.push_back(e);
  endtask

  initial begin
    rst_n = 1'b0; line_pin = 2'b01; mode_we = 1'b0; mode_wdata = 2'b00;
    trig_we = 1'b0; trig_wdata = 2'b00; irq_ack = 2'b00;
    tick(3);
    expect_in(1, 2'b00, 2'b00, "R1 reset state");
    tick(2);
    rst_n = 1'b1;
    expect_in(1, 2'b01, 2'b00, "R2 capture / R9 mask");
    expect_in(2, 2'b01, 2'b10, "R6 level B low after mask");
    tick(4);
    line_pin = 2'b10;
    expect_in(2, 2'b01, 2'b01, "R4 mode holds / R6 level follows");
    tick(4);
    line_pin = 2'b11;
    expect_in(2, 2'b01, 2'b00, "R6 no latch");
    tick(4);
    trig_we = 1'b1; trig_wdata = 2'b11;
    tick(1); trig_we = 1'b0;
    tick(2);
    line_pin = 2'b10;
    expect_in(2, 2'b01, 2'b00, "R7 not yet");
    expect_in(3, 2'b01, 2'b01, "R7 fall sets A");
    tick(4);
    line_pin = 2'b11;
    expect_in(3, 2'b01, 2'b01, "R7 sticky after rise");
    tick(4);
    trig_we = 1'b1; trig_wdata = 2'b01;
    expect_in(1, 2'b01, 2'b01, "R5 B to level, A still pending");
    tick(1); trig_we = 1'b0;
    line_pin = 2'b01;
    expect_in(2, 2'b01, 2'b11, "R5 R10 B level low");
    tick(4);
    trig_we = 1'b1; trig_wdata = 2'b11;
    expect_in(1, 2'b01, 2'b01, "R11 switch to edge while low");
    tick(1); trig_we = 1'b0;
    tick(2);
    line_pin = 2'b11;
    expect_in(3, 2'b01, 2'b01, "R11 rise does not set B");
    expect_in(4, 2'b01, 2'b01, "R11 rise does not set B later");
    tick(5);
    irq_ack = 2'b01;
    expect_in(1, 2'b01, 2'b00, "R8 ack clears A");
    tick(1); irq_ack = 2'b00;
    tick(2);
    line_pin = 2'b00;
    expect_in(3, 2'b01, 2'b11, "R10 both fall");
    tick(4);
    irq_ack = 2'b10;
    expect_in(1, 2'b01, 2'b01, "R10 ack B only");
    tick(1); irq_ack = 2'b00;
    tick(1);
    line_pin = 2'b01;
    tick(4);
    line_pin = 2'b00;
    tick(2);
    irq_ack = 2'b01;
    expect_in(1, 2'b01, 2'b01, "R8 fall wins over ack");
    tick(1); irq_ack = 2'b00;
    tick(2);
    irq_ack = 2'b01;
    expect_in(1, 2'b01, 2'b00, "R8 plain ack");
    tick(1); irq_ack = 2'b00;
    tick(2);
    mode_we = 1'b1; mode_wdata = 2'b10;
    expect_in(1, 2'b10, 2'b00, "R3 write 10");
    tick(1); mode_wdata = 2'b11;
    expect_in(1, 2'b11, 2'b00, "R3 write 11");
    tick(1); mode_we = 1'b0;
    tick(2);
    rst_n = 1'b0; line_pin = 2'b10; mode_we = 1'b1; mode_wdata = 2'b11;
    expect_in(1, 2'b00, 2'b00, "R1 async reset clears");
    tick(3);
    expect_in(1, 2'b00, 2'b00, "R1 write in reset ignored");
    tick(2);
    mode_we = 1'b0;
    tick(1);
    rst_n = 1'b1;
    expect_in(1, 2'b10, 2'b00, "R2 capture 10 / R9 mask");
    expect_in(2, 2'b10, 2'b01, "R5 reset to level, A low");
    tick(5);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule